// File: doc/BRIEF.md
# Fully Associative Tag Cache with Selectable Eviction

This block models the tag side of a fully associative cache. Every line is 32 bytes wide, any line can hold any block, and the number of lines is a parameter. On each clock the block can take one byte-address lookup. One cycle later it reports whether the lookup hit. On a miss it claims a line for the new block: the lowest-numbered empty line while one is left, and otherwise the victim picked by the eviction policy.

The eviction policy is fixed when the block is elaborated. One setting evicts the least recently touched line. The other evicts the most recently touched line, which keeps most of an oversized working set resident across repeated sequential sweeps. Each line keeps an age that shows how recently it was touched, and two counters add up the hits and the misses. Data storage, writes and the memory side are not modelled.

Top module: `fa_tag_cache`

## Requirements
- R1: After reset `rsp_valid` is 0, both counters are 0 and every line is empty, so the first lookup of any address misses.
- R2: The tag is `req_addr[ADDR_W-1:5]` and bits [4:0] are the byte offset. Any two addresses that differ only in bits [4:0] map to the same line, and at most one line matches a tag.
- R3: A lookup presented with `req_valid`=1 at a rising edge gives `rsp_valid`=1 and its `rsp_hit` result at the next edge. A cycle with `req_valid`=0 gives `rsp_valid`=0 and changes no counter and no line state.
- R4: While empty lines remain, a miss fills the lowest-numbered empty line and evicts nothing. The first LINES distinct blocks therefore all stay resident.
- R5: With the LRU policy and all lines full, a miss replaces the line whose last hit or fill is the oldest.
- R6: With the MRU policy and all lines full, a miss replaces the line whose last hit or fill is the newest.
- R7: `hit_count` goes up by one for each response with `rsp_hit`=1 and `miss_count` goes up by one for each response with `rsp_hit`=0. Both counters change in the same cycle as the response.
- R8: Two sequential byte sweeps over an array of exactly LINES*32 bytes give one miss per 32 accesses on the first sweep and only hits on the second. With 8 lines that is 8 misses and 504 hits.
- R9: Two sweeps over an array of 2*LINES*32 bytes miss once per 32 accesses on both sweeps under LRU (8 lines: 32 misses, 992 hits). Under MRU the second sweep misses only on the blocks in the middle of the array (8 lines: 24 misses, 1000 hits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | ADDR_W | Byte address of the lookup |
| rsp_valid | output | 1 | Result of the previous cycle's lookup is present |
| rsp_hit | output | 1 | 1 = hit, 0 = miss; meaningful when rsp_valid |
| hit_count | output | CNT_W | Hits since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
Two copies of the block, one per policy, are driven with the same stimulus. Each is compared on every clock with a behavioural recency list. Sweeps that fit exactly in the cache separate correct filling of empty lines from early eviction. Sweeps twice the cache size separate the two policies, since only correct victim selection yields 32 versus 24 misses. A short directed pattern fills every line, touches the first block again and then brings in a new one: the next access to the second-filled block misses under LRU but hits under MRU. Offset-only address changes and pseudo-random lookups with idle gaps between them check the tag split, that idle cycles change nothing, and the counters.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  typedef enum logic {EVICT_LRU = 1'b0, EVICT_MRU = 1'b1} evict_e;
endpackage

// File: rtl/ftc_tag_match.sv
module ftc_tag_match #(
  parameter int TAG_W = 27,
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0][TAG_W-1:0] line_tag,
  input  logic [LINES-1:0]            line_valid,
  input  logic [TAG_W-1:0]            look_tag,
  output logic [LINES-1:0]            hit_vec,
  output logic                        hit_any,
  output logic [IDX_W-1:0]            hit_idx
);
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = line_valid[g] && (line_tag[g] == look_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/ftc_victim_pick.sv
module ftc_victim_pick import ftc_pkg::*; #(
  parameter int     LINES  = 8,
  parameter evict_e POLICY = EVICT_LRU,
  localparam int IDX_W = $clog2(LINES),
  localparam int AGE_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]            line_valid,
  input  logic [LINES-1:0][AGE_W-1:0] line_age,
  output logic [IDX_W-1:0]            victim_idx
);
  logic [AGE_W-1:0] target_age;

  if (POLICY == EVICT_LRU) begin : g_lru
    assign target_age = AGE_W'(LINES - 1);
  end else begin : g_mru
    assign target_age = '0;
  end

  logic             empty_found;
  logic [IDX_W-1:0] empty_idx;
  logic [IDX_W-1:0] aged_idx;

  always_comb begin
    empty_found = 1'b0;
    empty_idx   = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!line_valid[i] && !empty_found) begin
        empty_found = 1'b1;
        empty_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    aged_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (line_age[i] == target_age) aged_idx = IDX_W'(i);
    end
  end

  assign victim_idx = empty_found ? empty_idx : aged_idx;
endmodule

// File: rtl/ftc_age_file.sv
module ftc_age_file #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int AGE_W = $clog2(LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch_en,
  input  logic [IDX_W-1:0]            touch_idx,
  input  logic [LINES-1:0]            line_valid,
  output logic [LINES-1:0][AGE_W-1:0] line_age
);
  logic [LINES-1:0][AGE_W-1:0] age_q, age_d;
  logic [AGE_W:0]              ref_age;

  // An empty line counts as older than every resident line.
  assign ref_age = line_valid[touch_idx] ? {1'b0, age_q[touch_idx]}
                                         : (AGE_W+1)'(LINES);

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == touch_idx) begin
          age_d[i] = '0;
        end else if (line_valid[i] && ({1'b0, age_q[i]} < ref_age)) begin
          age_d[i] = age_q[i] + AGE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assign line_age = age_q;
endmodule

// File: rtl/fa_tag_cache.sv
module fa_tag_cache import ftc_pkg::*; #(
  parameter int     ADDR_W     = 32,
  parameter int     LINE_BYTES = 32,
  parameter int     LINES      = 8,
  parameter int     CNT_W      = 16,
  parameter evict_e POLICY     = EVICT_LRU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int AGE_W = $clog2(LINES);

  logic [LINES-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [LINES-1:0]            valid_q, valid_d;
  logic [TAG_W-1:0]            look_tag;
  logic [LINES-1:0]            hit_vec;
  logic                        hit_any;
  logic [IDX_W-1:0]            hit_idx, victim_idx, touch_idx;
  logic [LINES-1:0][AGE_W-1:0] line_age;
  logic [CNT_W-1:0]            hit_cnt_d, miss_cnt_d;
  logic                        rsp_valid_d, rsp_hit_d;

  assign look_tag = req_addr[ADDR_W-1:OFF_W];

  ftc_tag_match #(.TAG_W(TAG_W), .LINES(LINES)) u_match (
    .line_tag  (tag_q),
    .line_valid(valid_q),
    .look_tag  (look_tag),
    .hit_vec   (hit_vec),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx)
  );

  ftc_victim_pick #(.LINES(LINES), .POLICY(POLICY)) u_victim (
    .line_valid(valid_q),
    .line_age  (line_age),
    .victim_idx(victim_idx)
  );

  assign touch_idx = hit_any ? hit_idx : victim_idx;

  ftc_age_file #(.LINES(LINES)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (req_valid),
    .touch_idx (touch_idx),
    .line_valid(valid_q),
    .line_age  (line_age)
  );

  // Next-state logic
  always_comb begin
    tag_d       = tag_q;
    valid_d     = valid_q;
    hit_cnt_d   = hit_count;
    miss_cnt_d  = miss_count;
    rsp_valid_d = req_valid;
    rsp_hit_d   = 1'b0;
    if (req_valid) begin
      rsp_hit_d = hit_any;
      if (hit_any) begin
        hit_cnt_d = hit_count + CNT_W'(1);
      end else begin
        miss_cnt_d           = miss_count + CNT_W'(1);
        tag_d[victim_idx]    = look_tag;
        valid_d[victim_idx]  = 1'b1;
      end
    end
  end

  // Registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      hit_count  <= hit_cnt_d;
      miss_count <= miss_cnt_d;
      rsp_valid  <= rsp_valid_d;
      rsp_hit    <= rsp_hit_d;
    end
  end

  // Tag storage needs no reset; a line is ignored until its valid bit is set.
  always_ff @(posedge clk) begin
    if (req_valid && !hit_any) tag_q <= tag_d;
  end
endmodule

// File: rtl/fa_tag_cache_chk.sv
module fa_tag_cache_chk #(
  parameter int CNT_W = 16,
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [LINES-1:0] hit_vec
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!rsp_valid && hit_count == '0 && miss_count == '0)
        else $error("reset state not clear");
    end
  end

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_no_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_idle_counts_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(hit_count) && $stable(miss_count)));

  assert_hit_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (hit_count == $past(hit_count) + CNT_W'(1)
                                && $stable(miss_count)));

  assert_miss_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (miss_count == $past(miss_count) + CNT_W'(1)
                                 && $stable(hit_count)));
endmodule

bind fa_tag_cache fa_tag_cache_chk #(.CNT_W(CNT_W), .LINES(LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .hit_count (hit_count),
  .miss_count(miss_count),
  .hit_vec   (hit_vec)
);

// File: tb/tb_fa_tag_cache.sv
module tb_fa_tag_cache;
  import ftc_pkg::*;

  localparam int LINES = 8;
  localparam int CNT_W = 16;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        v_lru, h_lru, v_mru, h_mru;
  logic [CNT_W-1:0] hc_lru, mc_lru, hc_mru, mc_mru;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  fa_tag_cache #(.LINES(LINES), .CNT_W(CNT_W), .POLICY(EVICT_LRU)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(v_lru), .rsp_hit(h_lru), .hit_count(hc_lru), .miss_count(mc_lru));

  fa_tag_cache #(.LINES(LINES), .CNT_W(CNT_W), .POLICY(EVICT_MRU)) dut_mru (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(v_mru), .rsp_hit(h_mru), .hit_count(hc_mru), .miss_count(mc_mru));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model: recency lists, front = most recently touched.
  int q_lru[$];
  int q_mru[$];
  int m_hits[2];
  int m_miss[2];

  function automatic bit model_access(input bit mru, input int t);
    int pos = -1;
    bit h;
    if (!mru) begin
      for (int i = 0; i < q_lru.size(); i++) if (q_lru[i] == t) pos = i;
      h = (pos >= 0);
      if (h) q_lru.delete(pos);
      else if (q_lru.size() == LINES) void'(q_lru.pop_back());
      q_lru.push_front(t);
    end else begin
      for (int i = 0; i < q_mru.size(); i++) if (q_mru[i] == t) pos = i;
      h = (pos >= 0);
      if (h) q_mru.delete(pos);
      else if (q_mru.size() == LINES) void'(q_mru.pop_front());
      q_mru.push_front(t);
    end
    if (h) m_hits[mru] = m_hits[mru] + 1;
    else   m_miss[mru] = m_miss[mru] + 1;
    return h;
  endfunction

  task automatic summary_and_end();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 200000", cyc);
      summary_and_end();
    end
  end

  task automatic check_one(input string tag, input string who, input logic v, input logic h,
                           input logic [CNT_W-1:0] hc, input logic [CNT_W-1:0] mc,
                           input bit ev, input bit eh, input int ehc, input int emc);
    checks = checks + 1;
    if (v !== ev || (ev && h !== eh) || hc !== CNT_W'(ehc) || mc !== CNT_W'(emc)) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual v=%0b h=%0b hits=%0d misses=%0d expected v=%0b h=%0b hits=%0d misses=%0d",
               tag, who, v, h, hc, mc, ev, eh, ehc, emc);
    end
  endtask

  // Called at a falling edge; response is checked at the next falling edge.
  task automatic step(input bit v, input logic [31:0] a, input string tag);
    bit el = 1'b0, em = 1'b0;
    req_valid = v;
    req_addr  = a;
    if (v) begin
      el = model_access(1'b0, int'(a >> 5));
      em = model_access(1'b1, int'(a >> 5));
    end
    @(posedge clk);
    @(negedge clk);
    check_one(tag, "lru", v_lru, h_lru, hc_lru, mc_lru, v, el, m_hits[0], m_miss[0]);
    check_one(tag, "mru", v_mru, h_mru, hc_mru, mc_mru, v, em, m_hits[1], m_miss[1]);
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    req_addr  = '0;
    rst_n     = 1'b0;
    q_lru.delete();
    q_mru.delete();
    m_hits = '{0, 0};
    m_miss = '{0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    check_one("R1", "lru", v_lru, h_lru, hc_lru, mc_lru, 1'b0, 1'b0, 0, 0);
    check_one("R1", "mru", v_mru, h_mru, hc_mru, mc_mru, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic sweep2(input int nbytes, input string tag);
    for (int j = 0; j < 2; j++)
      for (int i = 0; i < nbytes; i++)
        step(1'b1, 32'h0000_2000 + 32'(i), tag);
  endtask

  task automatic check_total(input string tag, input string who, input int hc, input int mc,
                             input int ehc, input int emc);
    checks = checks + 1;
    if (hc != ehc || mc != emc) begin
      fails = fails + 1;
      $display("FAIL %s %s totals: actual hits=%0d misses=%0d expected hits=%0d misses=%0d",
               tag, who, hc, mc, ehc, emc);
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    @(negedge clk);
    do_reset();

    // R1: the very first lookup misses
    step(1'b1, 32'h0000_0100, "R1");

    // R8: array equal to capacity
    do_reset();
    sweep2(LINES * 32, "R8");
    check_total("R8", "lru", int'(hc_lru), int'(mc_lru), 504, 8);
    check_total("R8", "mru", int'(hc_mru), int'(mc_mru), 504, 8);

    // R9: array twice the capacity
    do_reset();
    sweep2(LINES * 64, "R9");
    check_total("R9", "lru", int'(hc_lru), int'(mc_lru), 992, 32);
    check_total("R9", "mru", int'(hc_mru), int'(mc_mru), 1000, 24);

    // R2: offset bits do not change the line
    do_reset();
    step(1'b1, 32'h1000_0040, "R2");
    step(1'b1, 32'h1000_005F, "R2");
    step(1'b1, 32'h1000_0060, "R2");
    step(1'b1, 32'h1000_0041, "R2");

    // R4, R5, R6: fill all lines, retouch block 0, bring in a new block
    do_reset();
    for (int b = 0; b < LINES; b++) step(1'b1, 32'h0000_4000 + 32'(b * 32), "R4");
    for (int b = 0; b < LINES; b++) step(1'b1, 32'h0000_4000 + 32'(b * 32) + 7, "R4");
    step(1'b1, 32'h0000_4000, "R5");
    step(1'b1, 32'h0000_4000 + 32'(LINES * 32), "R6");
    // LRU evicted block 1 (miss); MRU evicted block 0 (block 1 hits)
    step(1'b1, 32'h0000_4020, "R5");
    step(1'b1, 32'h0000_4000, "R6");

    // R3, R7: pseudo-random lookups over 16 blocks with idle gaps
    begin
      logic [31:0] lcg = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        if (lcg[3:2] == 2'b00) step(1'b0, lcg, "R3");
        else step(1'b1, {20'h0, 3'b000, lcg[27:24], lcg[12:8]}, "R7");
      end
    end
    step(1'b0, 32'h0, "R3");
    step(1'b0, 32'hFFFF_FFFF, "R3");

    summary_and_end();
  end
endmodule